// File: doc/BRIEF.md
# Four-Way Instruction Address Translation Buffer

This block is a small, fully associative translation buffer on the instruction fetch path. It has four ways. Each way holds a virtual page tag, an address-space tag, a valid bit, a shared (global) bit, a two-bit page-size code, a physical page number, a user-execute permission bit and a cacheable bit. A fetch lookup compares the virtual address against all four ways in the same cycle. It reports a single hit, a miss or a multiple hit. On a hit it also gives the translated physical address, the hitting way, the cacheable bit and any protection violation.

Replacement follows a six-bit pairwise-order state. Each bit records which way of one pair was used less recently. A hit moves its way to most-recently-used, and so does a refill. When the larger unified translation buffer supplies a refill entry, the entry goes into the way that the state names as least recently used.

Top module: `ifetch_tlb`

## Requirements
- R1: After reset every way is invalid, `lru_o` is 0, and any lookup reports a miss.
- R2: A valid way matches when the address agrees with `{vpn,10'b0}` above its page offset. The offset width is 10, 12, 16 or 20 bits for size codes 0, 1, 2 or 3 (1 KB, 4 KB, 64 KB, 1 MB).
- R3: An invalid way never matches. The address-space tag is compared only when `asid_chk_i` is 1 and the way's shared bit is 0.
- R4: With `lookup_i` high, exactly one match gives `hit_o` with `hit_way_o` set to that way, no match gives `miss_o`, and two or more matches give `multi_o` with `hit_o` low.
- R5: On a hit, `paddr_o` is `{ppn,10'b0}` with its page-offset bits replaced by the address's low bits, and `cacheable_o` is the way's cacheable bit.
- R6: `prot_viol_o` is 1 on a hit with `user_i` high when the way's user-execute bit is 0. It is 0 in supervisor mode.
- R7: `lru_o[5:0]` is bits 7:2 of a state byte whose bits 1:0 read as 0. A hit on way 0 ANDs that byte with 0x1F. A hit on way 1 ANDs it with 0xE7 and ORs in 0x80. A hit on way 2 ANDs it with 0xFB and ORs in 0x50. A hit on way 3 ORs in 0x2C. The new state appears after the next clock edge.
- R8: The refill victim is chosen by the first of these tests that passes: way 0 if byte&0xE0==0xE0, way 1 if byte&0x98==0x18, way 2 if byte&0x54==0x04, way 3 if byte&0x2C==0. A refill writes the victim way and applies that way's update from R7.
- R9: When a refill and a hitting lookup fall in the same cycle, the lookup reports from the contents before the write, and only the refill's update is applied to the state.
- R10: With `lookup_i` low, every lookup output is 0 and the state holds. A miss or a multiple hit without a refill also leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_i | input | 1 | Fetch lookup request this cycle |
| vaddr_i | input | 32 | Virtual fetch address |
| asid_i | input | 8 | Current address-space tag |
| asid_chk_i | input | 1 | Enable address-space tag comparison |
| user_i | input | 1 | Fetch is in user mode |
| refill_i | input | 1 | Write refill entry into victim way |
| rf_vpn_i | input | 22 | Refill virtual page tag (address bits 31:10) |
| rf_asid_i | input | 8 | Refill address-space tag |
| rf_valid_i | input | 1 | Refill valid bit |
| rf_shared_i | input | 1 | Refill shared bit |
| rf_size_i | input | 2 | Refill page-size code |
| rf_ppn_i | input | 19 | Refill physical page number |
| rf_uexec_i | input | 1 | Refill user-execute permission |
| rf_cache_i | input | 1 | Refill cacheable bit |
| hit_o | output | 1 | Single match |
| miss_o | output | 1 | No match |
| multi_o | output | 1 | Two or more matches |
| prot_viol_o | output | 1 | User fetch from a supervisor-only page |
| hit_way_o | output | 2 | Index of the hitting way |
| paddr_o | output | 29 | Translated physical address |
| cacheable_o | output | 1 | Cacheable bit of the hitting way |
| lru_o | output | 6 | Replacement state |

## Verification
A hitting lookup and a refill can land in the same cycle. The hit wants to mark its own way as most recent, and the refill wants to overwrite the victim and mark that way instead. The bench first refills a fresh page so that it is most recent. It then looks that page up while a second refill is presented on the same clock edge. The lookup outputs are judged on the pre-write contents, the state after the edge must equal the refill-only update of the prior state, and a follow-up lookup must find the new page in the victim way.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 29;
  localparam int ASID_W  = 8;
  localparam int BASE_SH = 10;
  localparam int VPN_W   = VA_W - BASE_SH;
  localparam int PPN_W   = PA_W - BASE_SH;
  localparam int WAYS    = 4;
  localparam int WAY_W   = $clog2(WAYS);
  localparam int LRU_W   = 6;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [1:0]        size;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic              uexec;
    logic              cache;
  } entry_t;

  // page-offset mask per size code
  function automatic logic [VA_W-1:0] off_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    off_mask = VA_W'((1 << 10) - 1);
      2'd1:    off_mask = VA_W'((1 << 12) - 1);
      2'd2:    off_mask = VA_W'((1 << 16) - 1);
      default: off_mask = VA_W'((1 << 20) - 1);
    endcase
  endfunction
endpackage

// File: rtl/itlb_way_cmp.sv
module itlb_way_cmp
  import itlb_pkg::*;
(
  input  entry_t            ent_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              asid_chk_i,
  output logic              match_o,
  output logic [PA_W-1:0]   paddr_o
);
  logic [VA_W-1:0] om;
  logic [VA_W-1:0] base;
  logic [PA_W-1:0] pbase;
  logic            asid_ok;

  always_comb begin
    om      = off_mask(ent_i.size);
    base    = {ent_i.vpn, {BASE_SH{1'b0}}};
    pbase   = {ent_i.ppn, {BASE_SH{1'b0}}};
    asid_ok = !asid_chk_i || ent_i.shared || (ent_i.asid == asid_i);
    match_o = ent_i.valid && asid_ok && (((vaddr_i ^ base) & ~om) == '0);
    paddr_o = (pbase & ~om[PA_W-1:0]) | (vaddr_i[PA_W-1:0] & om[PA_W-1:0]);
  end
endmodule

// File: rtl/itlb_lru.sv
module itlb_lru
  import itlb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [WAY_W-1:0] upd_way_i,
  output logic [LRU_W-1:0] lru_o,
  output logic [WAY_W-1:0] victim_o
);
  logic [LRU_W-1:0] lru_q, lru_d;
  logic [7:0]       cur_b, nxt_b;
  logic             legal;

  always_comb begin
    cur_b = {lru_q, 2'b00};
    unique case (upd_way_i)
      2'd0:    nxt_b = cur_b & 8'h1F;
      2'd1:    nxt_b = (cur_b & 8'hE7) | 8'h80;
      2'd2:    nxt_b = (cur_b & 8'hFB) | 8'h50;
      default: nxt_b = cur_b | 8'h2C;
    endcase
    lru_d = upd_i ? nxt_b[7:2] : lru_q;
    legal = 1'b1;
    if      ((cur_b & 8'hE0) == 8'hE0) victim_o = 2'd0;
    else if ((cur_b & 8'h98) == 8'h18) victim_o = 2'd1;
    else if ((cur_b & 8'h54) == 8'h04) victim_o = 2'd2;
    else if ((cur_b & 8'h2C) == 8'h00) victim_o = 2'd3;
    else begin
      victim_o = 2'd0;  // unreachable cyclic order: fall back to way 0
      legal    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lru_q <= '0;
    else         lru_q <= lru_d;

  assign lru_o = lru_q;

  // R8
  lru_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) legal);
  // R10
  lru_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(lru_q));
  // R7
  lru_mru0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_way_i == 2'd0) |=> (lru_q[5:3] == 3'b000));
  // R7
  lru_mru3_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && upd_way_i == 2'd3) |=> (lru_q[3] && lru_q[1] && lru_q[0]));
endmodule

// File: rtl/ifetch_tlb.sv
module ifetch_tlb
  import itlb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              asid_chk_i,
  input  logic              user_i,
  input  logic              refill_i,
  input  logic [VPN_W-1:0]  rf_vpn_i,
  input  logic [ASID_W-1:0] rf_asid_i,
  input  logic              rf_valid_i,
  input  logic              rf_shared_i,
  input  logic [1:0]        rf_size_i,
  input  logic [PPN_W-1:0]  rf_ppn_i,
  input  logic              rf_uexec_i,
  input  logic              rf_cache_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic              multi_o,
  output logic              prot_viol_o,
  output logic [WAY_W-1:0]  hit_way_o,
  output logic [PA_W-1:0]   paddr_o,
  output logic              cacheable_o,
  output logic [LRU_W-1:0]  lru_o
);
  entry_t           ent_q [WAYS];
  entry_t           rf_ent;
  logic [WAYS-1:0]  match;
  logic [PA_W-1:0]  pa_w [WAYS];
  logic [WAY_W-1:0] way_enc, victim;
  logic [2:0]       n_match;
  logic             lru_upd;
  logic [WAY_W-1:0] lru_way;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    itlb_way_cmp u_cmp (
      .ent_i      (ent_q[g]),
      .vaddr_i    (vaddr_i),
      .asid_i     (asid_i),
      .asid_chk_i (asid_chk_i),
      .match_o    (match[g]),
      .paddr_o    (pa_w[g])
    );
  end

  always_comb begin
    way_enc = '0;
    for (int i = 0; i < WAYS; i++)
      if (match[i]) way_enc = WAY_W'(i);
    n_match = 3'($countones(match));
  end

  assign hit_o       = lookup_i && (n_match == 3'd1);
  assign miss_o      = lookup_i && (n_match == 3'd0);
  assign multi_o     = lookup_i && (n_match > 3'd1);
  assign hit_way_o   = hit_o ? way_enc : '0;
  assign paddr_o     = hit_o ? pa_w[way_enc] : '0;
  assign cacheable_o = hit_o && ent_q[way_enc].cache;
  assign prot_viol_o = hit_o && user_i && !ent_q[way_enc].uexec;

  // refill owns the replacement update when both occur
  assign lru_upd = refill_i || hit_o;
  assign lru_way = refill_i ? victim : way_enc;

  itlb_lru u_lru (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (lru_upd),
    .upd_way_i (lru_way),
    .lru_o     (lru_o),
    .victim_o  (victim)
  );

  always_comb begin
    rf_ent        = '0;
    rf_ent.valid  = rf_valid_i;
    rf_ent.shared = rf_shared_i;
    rf_ent.size   = rf_size_i;
    rf_ent.vpn    = rf_vpn_i;
    rf_ent.asid   = rf_asid_i;
    rf_ent.ppn    = rf_ppn_i;
    rf_ent.uexec  = rf_uexec_i;
    rf_ent.cache  = rf_cache_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WAYS; i++) ent_q[i] <= '0;
    end else if (refill_i) begin
      ent_q[victim] <= rf_ent;
    end
  end

  // R4
  lookup_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |-> ($countones({hit_o, miss_o, multi_o}) == 1));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |-> !(hit_o || miss_o || multi_o || prot_viol_o));
  // R6
  viol_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_viol_o |-> (hit_o && user_i));
  // R8
  refill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (refill_i && rf_valid_i) |=> ent_q[$past(victim)].valid);
endmodule

// File: tb/ifetch_tlb_test.sv
module ifetch_tlb_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic        lookup_i = 0, asid_chk_i = 0, user_i = 0, refill_i = 0;
  logic [31:0] vaddr_i = '0;
  logic [7:0]  asid_i = '0, rf_asid_i = '0;
  logic [21:0] rf_vpn_i = '0;
  logic        rf_valid_i = 0, rf_shared_i = 0, rf_uexec_i = 0, rf_cache_i = 0;
  logic [1:0]  rf_size_i = '0;
  logic [18:0] rf_ppn_i = '0;
  logic        hit_o, miss_o, multi_o, prot_viol_o, cacheable_o;
  logic [1:0]  hit_way_o;
  logic [28:0] paddr_o;
  logic [5:0]  lru_o;

  int checks = 0, errors = 0;
  logic [5:0] m_lru = '0;
  logic [1:0] v_a, v_g, v_h;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ifetch_tlb uut (.*);

  typedef struct packed {
    logic [31:0] va; logic [7:0] asid; logic chk; logic user;
    logic hit; logic miss; logic multi; logic viol;
    logic [1:0] way; logic [28:0] pa; logic cache;
  } vec_t;

  // ways after preload: A=3 (1K), B=2 (4K shared, sup-only), C=1 (64K), D=0 (1M)
  localparam vec_t VECS [12] = '{
    '{32'h0040_0123, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 29'h0004_0123, 1'b1},
    '{32'h0040_0400, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 29'h0,          1'b0},
    '{32'h1000_0ABC, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 29'h0008_0ABC, 1'b0},
    '{32'h1000_0ABC, 8'h11, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 29'h0008_0ABC, 1'b0},
    '{32'h2000_BEEF, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 29'h0011_BEEF, 1'b1},
    '{32'h2000_BEEF, 8'h44, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 29'h0,          1'b0},
    '{32'h2000_BEEF, 8'h44, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 29'h0011_BEEF, 1'b1},
    '{32'h300F_FFFF, 8'h33, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 29'h004F_FFFF, 1'b0},
    '{32'h3010_0000, 8'h33, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 29'h0,          1'b0},
    '{32'h0040_03FF, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 29'h0004_03FF, 1'b1},
    '{32'h1000_1000, 8'h11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 29'h0,          1'b0},
    '{32'h2001_0000, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 29'h0,          1'b0}
  };

  function automatic logic [5:0] m_upd(input logic [5:0] l, input logic [1:0] w);
    logic [7:0] b = {l, 2'b00};
    case (w)
      2'd0: b = b & 8'h1F;
      2'd1: b = (b & 8'hE7) | 8'h80;
      2'd2: b = (b & 8'hFB) | 8'h50;
      default: b = b | 8'h2C;
    endcase
    return b[7:2];
  endfunction

  function automatic logic [1:0] m_vic(input logic [5:0] l);
    logic [7:0] b = {l, 2'b00};
    if ((b & 8'hE0) == 8'hE0) return 2'd0;
    if ((b & 8'h98) == 8'h18) return 2'd1;
    if ((b & 8'h54) == 8'h04) return 2'd2;
    return 2'd3;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // starts and ends at a falling edge
  task automatic refill(input logic [31:0] va, input logic [7:0] asid, input logic v,
                        input logic sh, input logic [1:0] sz, input logic [18:0] ppn,
                        input logic ux, input logic c, output logic [1:0] vic);
    refill_i = 1; rf_vpn_i = va[31:10]; rf_asid_i = asid; rf_valid_i = v;
    rf_shared_i = sh; rf_size_i = sz; rf_ppn_i = ppn; rf_uexec_i = ux; rf_cache_i = c;
    vic = m_vic(m_lru);
    @(posedge clk_i); #1;
    refill_i = 0;
    m_lru = m_upd(m_lru, vic);
    chk(lru_o == m_lru, "R8 refill victim update", 32'(lru_o), 32'(m_lru));
    @(negedge clk_i);
  endtask

  task automatic lookup(input vec_t t, input string req);
    lookup_i = 1; vaddr_i = t.va; asid_i = t.asid; asid_chk_i = t.chk; user_i = t.user;
    #1;
    chk({hit_o, miss_o, multi_o, prot_viol_o} == {t.hit, t.miss, t.multi, t.viol},
        {req, " flags"}, 32'({hit_o, miss_o, multi_o, prot_viol_o}),
        32'({t.hit, t.miss, t.multi, t.viol}));
    if (t.hit)
      chk({hit_way_o, paddr_o, cacheable_o} == {t.way, t.pa, t.cache},
          {req, " R5 way/paddr/cache"}, {hit_way_o, paddr_o, cacheable_o},
          {t.way, t.pa, t.cache});
    @(posedge clk_i); #1;
    lookup_i = 0;
    if (t.hit) m_lru = m_upd(m_lru, t.way);
    chk(lru_o == m_lru, {req, " R7 lru"}, 32'(lru_o), 32'(m_lru));
    @(negedge clk_i);
  endtask

  logic [1:0] dummy;
  logic [5:0] lru_before;

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(lru_o == 6'd0, "R1 reset lru", 32'(lru_o), 0);
    lookup('{32'h0040_0123, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 29'h0, 1'b0}, "R1 reset miss");

    // preload: victims 3,2,1,0 from reset state (R8)
    refill(32'h0040_0000, 8'h11, 1, 0, 2'd0, 19'h00100, 1, 1, dummy);
    chk(dummy == 2'd3, "R8 first victim", 32'(dummy), 3);
    refill(32'h1000_0000, 8'h22, 1, 1, 2'd1, 19'h00200, 0, 0, dummy);
    chk(dummy == 2'd2, "R8 second victim", 32'(dummy), 2);
    refill(32'h2000_0000, 8'h11, 1, 0, 2'd2, 19'h00455, 1, 1, dummy);
    refill(32'h3000_0000, 8'h33, 1, 0, 2'd3, 19'h01000, 1, 0, dummy);
    chk(dummy == 2'd0, "R8 fourth victim", 32'(dummy), 0);

    // R2 R3 R4 R5 R6 R7 table walk
    foreach (VECS[i]) lookup(VECS[i], $sformatf("R2/R3/R4/R6 vec%0d", i));

    // R4 multi-hit: make way 3 most recent, then overlap it
    lookup(VECS[0], "R7 mru way3");
    refill(32'h0040_0000, 8'h11, 1, 0, 2'd1, 19'h00777, 1, 0, v_a);
    chk(v_a != 2'd3, "R8 victim not mru", 32'(v_a), 3);
    lookup('{32'h0040_0010, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 29'h0, 1'b0}, "R4 multi");

    // R3 invalid refill never matches
    refill(32'h5000_0000, 8'h11, 0, 1, 2'd3, 19'h00010, 1, 0, dummy);
    lookup('{32'h5000_0000, 8'h11, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 29'h0, 1'b0}, "R3 invalid");

    // R9 hit and refill in the same cycle
    refill(32'h6000_0000, 8'h11, 1, 0, 2'd0, 19'h00003, 1, 1, v_g);
    lookup_i = 1; vaddr_i = 32'h6000_0005; asid_i = 8'h11; asid_chk_i = 1; user_i = 1;
    refill_i = 1; rf_vpn_i = 22'(32'h7000_0000 >> 10); rf_asid_i = 8'h11; rf_valid_i = 1;
    rf_shared_i = 0; rf_size_i = 2'd0; rf_ppn_i = 19'h00009; rf_uexec_i = 1; rf_cache_i = 0;
    v_h = m_vic(m_lru);
    lru_before = m_lru;
    #1;
    chk(hit_o && hit_way_o == v_g && paddr_o == 29'h0C05, "R9 hit during refill",
        {hit_o, hit_way_o, paddr_o}, {1'b1, v_g, 29'h0C05});
    @(posedge clk_i); #1;
    lookup_i = 0; refill_i = 0;
    m_lru = m_upd(lru_before, v_h);
    chk(lru_o == m_lru, "R9 refill update wins", 32'(lru_o), 32'(m_lru));
    @(negedge clk_i);
    lookup('{32'h7000_0001, 8'h11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, v_h, 29'h2401, 1'b0}, "R9 new page");

    // R10 idle lookup is quiet and holds state
    vaddr_i = 32'h7000_0001; lookup_i = 0;
    #1;
    chk({hit_o, miss_o, multi_o, prot_viol_o} == 4'b0, "R10 idle outputs",
        32'({hit_o, miss_o, multi_o, prot_viol_o}), 0);
    @(posedge clk_i); #1;
    chk(lru_o == m_lru, "R10 idle lru hold", 32'(lru_o), 32'(m_lru));
    @(negedge clk_i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule